// File: doc/BRIEF.md
# Asynchronous Serial Port with Clock-Factor Modes

This block is a byte-wide asynchronous transmitter and receiver that sits on a small 8-bit processor bus. It takes its bit timing from two clocks supplied from outside, one for sending and one for receiving. A mode setting chooses how many of those clock cycles make up one serial bit: 1, 16 or 64. Both clock inputs and the serial receive line are synchronised into the system clock domain. A bit step happens on each synchronised rising edge of the external clock.

In the 16 and 64 modes, the receiver looks for a falling start edge on every oversampling tick. It checks the start bit again at its midpoint and then samples every later bit one bit period apart. Because timing restarts from each new start edge, a small rate mismatch does not build up across a long run of back-to-back characters. In x1 mode each bit is sampled once, on a receive clock edge.

The processor side has two addresses selected by chip select and active-low read and write strobes. Data flows through the port under a simple back-pressure rule. A byte may be written only while transmitter-ready is high; a data write while it is low is dropped. A received byte stays in the data register until the next complete frame replaces it, so software must read it while receiver-ready is set.

Top module: `serial_port`

## Requirements
- R1: After reset, txd is high, the status byte reads 0x01 (transmitter-ready set, receiver-ready and framing error clear), the factor is x16, and rdata is 0 whenever the port is not being read.
- R2: Address 0 is the data register and address 1 the control/status register. A register is read only while cs_n and rd_n are both low. The status bits are: bit 0 transmitter-ready, bit 1 receiver-ready, bit 2 framing error, and all other bits 0.
- R3: A control write with bit 7 set is a mode write, and bits 1:0 select the factor: 00 = x1, 01 = x16, 10 or 11 = x64. A control write with bit 7 clear is a command, and bit 4 set in a command clears the framing error.
- R4: Each transmitted frame is one low start bit, then eight data bits least-significant first, then one high stop bit. Each bit lasts factor rising edges of txc.
- R5: Transmitter-ready is low while the holding register is full. A data write while it is low is ignored. A byte waiting in the holding register starts right after the previous stop bit, with no idle gap.
- R6: In x16 and x64 modes the receiver hunts for a low line on every rxc tick. It rechecks the start bit half a bit later, then samples each data bit and the stop bit one full bit period apart.
- R7: A low pulse on rxd that has ended by the mid-start check is ignored, and a later valid frame is still received correctly.
- R8: In x1 mode each bit is sampled once, on a rising edge of rxc.
- R9: Receiver-ready is set when a frame completes. Reading the data register clears it.
- R10: A stop bit sampled low sets the framing error and still delivers the byte. The error stays set, even across a data read, until a clearing command. After such a frame the receiver waits for a high line before it hunts again.
- R11: Back-to-back frames sent about 1.5% faster than the nominal x16 rate are all received correctly, because the bit timing restarts from each start edge.
- R12: txd changes only on the system clock edge that follows a detected txc rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 1 | Register select: 0 data, 1 control/status |
| wdata | input | 8 | Write data from the processor |
| rdata | output | 8 | Read data, zero when not reading |
| txc | input | 1 | External transmit clock |
| rxc | input | 1 | External receive clock |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, idle high |

## Verification
Transmit is tried with a lone byte and with two queued bytes plus an extra write while full. This separates correct framing from correct holding-register handoff and from honouring back-pressure. Receive is tried at all three factors: x1 exposes the edge-aligned single sample, while x16 and x64 expose the mid-start recheck and the bit spacing. A short low glitch separates the start recheck from plain edge triggering, and a frame with a low stop bit checks the sticky error and the wait for a high line. A run of eight frames sent slightly too fast tells per-frame realignment apart from free-running bit timing, which would drift out of the stop bit.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int CNT_W = 7;

  typedef enum logic [1:0] {
    FAC_X1   = 2'b00,
    FAC_X16  = 2'b01,
    FAC_X64  = 2'b10,
    FAC_X64B = 2'b11
  } factor_e;

  localparam int STAT_TXRDY = 0;
  localparam int STAT_RXRDY = 1;
  localparam int STAT_FERR  = 2;
  localparam int CTL_MODE   = 7;
  localparam int CTL_CLRFE  = 4;

  function automatic logic [CNT_W-1:0] factor_len(input factor_e f);
    case (f)
      FAC_X1:  return CNT_W'(1);
      FAC_X16: return CNT_W'(16);
      default: return CNT_W'(64);
    endcase
  endfunction
endpackage

// File: rtl/sp_edge.sv
module sp_edge #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= {(STAGES+1){INIT}};
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign lvl  = sh[STAGES-1];
  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/sp_tx.sv
module sp_tx
  import sp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] len,
  input  logic             load,
  input  logic [DW-1:0]    din,
  output logic             hold_full,
  output logic             busy,
  output logic             txd
);
  localparam int FW = DW + 2;
  localparam int BW = $clog2(FW + 1);

  logic [DW-1:0]    hold;
  logic [FW-1:0]    sh;
  logic [BW-1:0]    bitn;
  logic [CNT_W-1:0] tcnt;
  logic             bit_end, frame_end, take;

  assign bit_end   = busy && tick && (tcnt == len - 1'b1);
  assign frame_end = bit_end && (bitn == BW'(FW - 1));
  assign take      = tick && hold_full && (!busy || frame_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= '0;
      hold_full <= 1'b0;
      sh        <= '1;
      bitn      <= '0;
      tcnt      <= '0;
      busy      <= 1'b0;
    end else begin
      if (load) begin
        hold      <= din;
        hold_full <= 1'b1;
      end else if (take) begin
        hold_full <= 1'b0;
      end
      if (take) begin
        sh   <= {1'b1, hold, 1'b0};
        bitn <= '0;
        tcnt <= '0;
        busy <= 1'b1;
      end else if (busy && tick) begin
        if (bit_end) begin
          tcnt <= '0;
          if (frame_end) begin
            busy <= 1'b0;
            sh   <= '1;
          end else begin
            sh   <= {1'b1, sh[FW-1:1]};
            bitn <= bitn + 1'b1;
          end
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end

  assign txd = sh[0];
endmodule

// File: rtl/sp_rx.sv
module sp_rx
  import sp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rxd,
  input  logic [CNT_W-1:0] len,
  output logic             done,
  output logic             ferr,
  output logic [DW-1:0]    data
);
  localparam int BW = $clog2(DW + 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS, S_WAIT} rx_st_e;

  rx_st_e           st;
  logic [CNT_W-1:0] tcnt;
  logic [BW-1:0]    bitn;
  logic [DW-1:0]    sh;
  logic [CNT_W-1:0] half;
  logic             single;

  assign half   = len >> 1;
  assign single = (len == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      tcnt <= '0;
      bitn <= '0;
      sh   <= '0;
      done <= 1'b0;
      ferr <= 1'b0;
      data <= '0;
    end else begin
      done <= 1'b0;
      ferr <= 1'b0;
      if (tick) begin
        case (st)
          S_IDLE: if (!rxd) begin
            tcnt <= '0;
            bitn <= '0;
            st   <= single ? S_BITS : S_START;
          end
          S_START: begin
            if (tcnt == half - 1'b1) begin
              tcnt <= '0;
              st   <= rxd ? S_IDLE : S_BITS;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          S_BITS: begin
            if (tcnt == len - 1'b1) begin
              tcnt <= '0;
              if (bitn == BW'(DW)) begin
                done <= 1'b1;
                data <= sh;
                ferr <= ~rxd;
                st   <= rxd ? S_IDLE : S_WAIT;
              end else begin
                sh   <= {rxd, sh[DW-1:1]};
                bitn <= bitn + 1'b1;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
          default: if (rxd) st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_port.sv
module serial_port
  import sp_pkg::*;
#(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          txc,
  input  logic          rxc,
  output logic          txd,
  input  logic          rxd
);
  logic             rd_act, wr_act, rd_q, wr_q;
  logic             rd_start, wr_start;
  logic             load, clear_fe;
  factor_e          fac;
  logic [CNT_W-1:0] len;
  logic             tx_tick, rx_tick, txc_lvl_unused, rxc_lvl_unused;
  logic [SYNC_STAGES-1:0] rxd_sync;
  logic             rxd_s;
  logic             hold_full, tx_busy;
  logic             rx_done, rx_ferr;
  logic [DW-1:0]    rx_data;
  logic             rx_ready, frame_err;
  logic [DW-1:0]    status;
  logic             unused_bits;

  assign unused_bits = ^{wdata[6:5], wdata[3:2]};

  assign rd_act   = ~cs_n & ~rd_n;
  assign wr_act   = ~cs_n & ~wr_n;
  assign rd_start = rd_act & ~rd_q;
  assign wr_start = wr_act & ~wr_q;
  assign load     = wr_start & ~addr & ~hold_full;
  assign clear_fe = wr_start & addr & ~wdata[CTL_MODE] & wdata[CTL_CLRFE];
  assign len      = factor_len(fac);

  sp_edge #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_txc_edge (
    .clk(clk), .rst_n(rst_n), .din(txc), .lvl(txc_lvl_unused), .rise(tx_tick));
  sp_edge #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_rxc_edge (
    .clk(clk), .rst_n(rst_n), .din(rxc), .lvl(rxc_lvl_unused), .rise(rx_tick));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rxd_sync <= '1;
    else        rxd_sync <= {rxd_sync[SYNC_STAGES-2:0], rxd};
  end
  assign rxd_s = rxd_sync[SYNC_STAGES-1];

  sp_tx #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tx_tick), .len(len), .load(load),
    .din(wdata), .hold_full(hold_full), .busy(tx_busy), .txd(txd));

  sp_rx #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(rx_tick), .rxd(rxd_s), .len(len),
    .done(rx_done), .ferr(rx_ferr), .data(rx_data));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q      <= 1'b0;
      wr_q      <= 1'b0;
      fac       <= FAC_X16;
      rx_ready  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      rd_q <= rd_act;
      wr_q <= wr_act;
      if (wr_start && addr && wdata[CTL_MODE]) fac <= factor_e'(wdata[1:0]);
      if (rx_done)                  rx_ready <= 1'b1;
      else if (rd_start && !addr)   rx_ready <= 1'b0;
      if (rx_ferr)       frame_err <= 1'b1;
      else if (clear_fe) frame_err <= 1'b0;
    end
  end

  always_comb begin
    status             = '0;
    status[STAT_TXRDY] = ~hold_full;
    status[STAT_RXRDY] = rx_ready;
    status[STAT_FERR]  = frame_err;
    if (!rd_act)   rdata = '0;
    else if (addr) rdata = status;
    else           rdata = rx_data;
  end
endmodule

// File: rtl/sp_checker.sv
module sp_checker (
  input logic clk,
  input logic rst_n,
  input logic txd,
  input logic tx_tick,
  input logic tx_busy,
  input logic hold_full,
  input logic rx_done,
  input logic rx_ready,
  input logic frame_err,
  input logic clear_fe,
  input logic rd_start,
  input logic addr
);
  p_txd_on_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_tick |=> $stable(txd));

  p_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd);

  p_hold_waits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !tx_tick) |=> hold_full);

  p_ready_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(rx_done));

  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && !addr && !rx_done) |=> !rx_ready);

  p_fe_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && !clear_fe) |=> frame_err);
endmodule

bind serial_port sp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .tx_tick(tx_tick), .tx_busy(tx_busy),
  .hold_full(hold_full), .rx_done(rx_done), .rx_ready(rx_ready),
  .frame_err(frame_err), .clear_fe(clear_fe), .rd_start(rd_start), .addr(addr));

// File: tb/serial_port_test.sv
module serial_port_test;
  localparam int CLK      = 10;
  localparam int TXC_HALF = 2;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       txc = 1'b0, rxc = 1'b0, rxd = 1'b1, txd;
  int         rx_half = 2;
  int         vectors = 0, fails = 0, cyc = 0;

  serial_port uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .txc(txc), .rxc(rxc),
    .txd(txd), .rxd(rxd));

  always #(CLK/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always begin repeat (TXC_HALF) @(negedge clk); txc = ~txc; end
  always begin repeat (rx_half) @(negedge clk); rxc = ~rxc; end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk); cs_n = 0; wr_n = 0; addr = a; wdata = d;
    @(negedge clk); cs_n = 1; wr_n = 1;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    @(negedge clk); cs_n = 0; rd_n = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); cs_n = 1; rd_n = 1;
  endtask

  task automatic wait_status(input int bitn, input int limit, output bit ok);
    logic [7:0] s;
    ok = 0;
    for (int i = 0; i < limit && !ok; i++) begin
      bus_read(1'b1, s);
      if (s[bitn]) ok = 1;
    end
  endtask

  task automatic decode_tx(input int bitclk, output logic [7:0] b, output logic stopv,
                           output int t0);
    int n = 0;
    @(negedge clk);
    while (txd !== 1'b0 && n < 20000) begin @(negedge clk); n++; end
    t0 = cyc;
    repeat (bitclk/2) @(negedge clk);
    chk("R4 start bit low", {31'd0, txd}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      repeat (bitclk) @(negedge clk);
      b[i] = txd;
    end
    repeat (bitclk) @(negedge clk);
    stopv = txd;
  endtask

  task automatic send_os(input logic [7:0] b, input int bitclk, input logic stopv);
    @(negedge clk); rxd = 0;
    repeat (bitclk - 1) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (bitclk) @(negedge clk);
    end
    rxd = stopv;
    repeat (bitclk - 1) @(negedge clk);
  endtask

  task automatic send_x1(input logic [7:0] b);
    @(negedge rxc); rxd = 0;
    for (int i = 0; i < 8; i++) begin @(negedge rxc); rxd = b[i]; end
    @(negedge rxc); rxd = 1;
    @(negedge rxc); @(negedge rxc);
  endtask

  task automatic t_reset;
    logic [7:0] s;
    chk("R1 txd idle high", {31'd0, txd}, 32'd1);
    chk("R1 rdata zero when idle", {24'd0, rdata}, 32'd0);
    bus_read(1'b1, s);
    chk("R1 R2 reset status", {24'd0, s}, 32'h01);
  endtask

  task automatic t_tx_single;
    logic [7:0] b; logic sv; int t0;
    fork
      decode_tx(64, b, sv, t0);
      bus_write(1'b0, 8'hA5);
    join
    chk("R4 x16 data LSB first", {24'd0, b}, 32'hA5);
    chk("R4 stop bit high", {31'd0, sv}, 32'd1);
  endtask

  task automatic t_tx_b2b;
    logic [7:0] b1, b2, s; logic sv1, sv2; int t1, t2; bit ok; int lows;
    fork
      begin
        decode_tx(64, b1, sv1, t1);
        decode_tx(64, b2, sv2, t2);
      end
      begin
        bus_write(1'b0, 8'h3C);
        wait_status(0, 50, ok);
        chk("R5 ready after hand-off", {31'd0, ok}, 32'd1);
        bus_write(1'b0, 8'hC3);
        bus_read(1'b1, s);
        chk("R5 ready low while holding full", {31'd0, s[0]}, 32'd0);
        bus_write(1'b0, 8'hFF);
      end
    join
    chk("R5 first byte", {24'd0, b1}, 32'h3C);
    chk("R5 second byte", {24'd0, b2}, 32'hC3);
    // R12: frame length counts exactly 16 txc edges per bit
    chk("R5 R12 no gap between frames", t2 - t1, 32'd640);
    lows = 0;
    repeat (1200) begin @(negedge clk); if (txd === 1'b0) lows++; end
    chk("R5 write while full ignored", lows, 32'd0);
  endtask

  task automatic t_tx_x64;
    logic [7:0] b; logic sv; int t0;
    bus_write(1'b1, 8'h82);
    fork
      decode_tx(256, b, sv, t0);
      bus_write(1'b0, 8'h5E);
    join
    chk("R3 R12 x64 transmit byte", {24'd0, b}, 32'h5E);
    chk("R4 x64 stop high", {31'd0, sv}, 32'd1);
    repeat (300) @(negedge clk);
  endtask

  task automatic rx_expect(input string tag, input logic [7:0] exp);
    logic [7:0] d, s; bit ok;
    wait_status(1, 400, ok);
    chk({tag, " ready set"}, {31'd0, ok}, 32'd1);
    bus_read(1'b0, d);
    chk({tag, " data"}, {24'd0, d}, {24'd0, exp});
    bus_read(1'b1, s);
    chk("R9 read clears receiver-ready", {31'd0, s[1]}, 32'd0);
  endtask

  task automatic t_rx_x16;
    bus_write(1'b1, 8'h81);
    send_os(8'h96, 64, 1'b1);
    rx_expect("R6 x16 receive", 8'h96);
  endtask

  task automatic t_rx_x64;
    bus_write(1'b1, 8'h83);
    send_os(8'h4B, 256, 1'b1);
    rx_expect("R3 R6 x64 receive", 8'h4B);
  endtask

  task automatic t_rx_x1;
    rx_half = 4;
    bus_write(1'b1, 8'h80);
    repeat (20) @(negedge clk);
    send_x1(8'hD2);
    rx_expect("R8 x1 receive", 8'hD2);
    send_x1(8'h01);
    rx_expect("R8 x1 second byte", 8'h01);
    bus_write(1'b1, 8'h81);
    rx_half = 2;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_glitch;
    logic [7:0] s;
    @(negedge clk); rxd = 0;
    repeat (12) @(negedge clk); rxd = 1;
    repeat (1500) @(negedge clk);
    bus_read(1'b1, s);
    chk("R7 glitch gives no byte", {31'd0, s[1]}, 32'd0);
    send_os(8'h5A, 64, 1'b1);
    rx_expect("R7 frame after glitch", 8'h5A);
  endtask

  task automatic t_framing;
    logic [7:0] s, d; bit ok;
    send_os(8'h81, 64, 1'b0);
    rxd = 1;
    wait_status(1, 400, ok);
    bus_read(1'b1, s);
    chk("R10 framing error set", {31'd0, s[2]}, 32'd1);
    bus_read(1'b0, d);
    chk("R10 byte still delivered", {24'd0, d}, 32'h81);
    repeat (1500) @(negedge clk);
    bus_read(1'b1, s);
    chk("R10 no spurious frame", {31'd0, s[1]}, 32'd0);
    chk("R10 error sticky across read", {31'd0, s[2]}, 32'd1);
    bus_write(1'b1, 8'h01);
    bus_read(1'b1, s);
    chk("R3 command without clear bit", {31'd0, s[2]}, 32'd1);
    bus_write(1'b1, 8'h10);
    bus_read(1'b1, s);
    chk("R3 R10 clear command", {31'd0, s[2]}, 32'd0);
  endtask

  task automatic t_drift;
    logic [7:0] got [8];
    logic [7:0] s;
    fork
      begin
        for (int k = 0; k < 8; k++) send_os(8'h11 * k[7:0] + 8'h0F, 63, 1'b1);
        rxd = 1;
      end
      begin
        for (int k = 0; k < 8; k++) begin
          bit ok;
          wait_status(1, 800, ok);
          bus_read(1'b0, got[k]);
        end
      end
    join
    for (int k = 0; k < 8; k++)
      chk("R11 back-to-back fast frame", {24'd0, got[k]}, {24'd0, 8'h11 * k[7:0] + 8'h0F});
    bus_read(1'b1, s);
    chk("R11 no framing error", {31'd0, s[2]}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_tx_single();
    t_tx_b2b();
    t_rx_x16();
    t_glitch();
    t_framing();
    t_rx_x1();
    t_drift();
    t_rx_x64();
    t_tx_x64();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule